// File: doc/BRIEF.md
# Handshake Modulo-Six Event Counter

This clocked control block counts events that arrive as four-phase handshakes on one input channel. It answers each event with a full four-phase handshake on one of two output channels. The first five events of every cycle go out on the step channel. The sixth goes out on the wrap channel, and the block then begins a new cycle. The cycle length is a parameter, and its default is six.

The block does not acknowledge an input event until the chosen output channel has acknowledged its request. Because of this, an event is never lost and never counted twice. All channels are plain request/acknowledge pairs and carry no data. Back-pressure therefore comes from the handshake itself: each side stalls simply by not moving its own wire. There is no separate valid/ready pair.

Every channel follows the same return-to-zero order:
1. The request rises.
2. The acknowledge rises.
3. The request falls.
4. The acknowledge falls.

Top module: `hs_mod_counter`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `ev_ack`, `step_req` and `wrap_req` are all 0, and the first event after reset goes to the step channel.
- R2: Within each cycle of CYCLE_LEN (6) input events, events 1 to 5 raise `step_req` and event 6 raises `wrap_req`. The sequence then repeats from event 1.
- R3: `step_req` and `wrap_req` are never 1 at the same time.
- R4: `ev_ack` rises only after the acknowledge of the selected output channel was high at the preceding clock edge.
- R5: An output request, once raised, stays high until its acknowledge is seen high.
- R6: `ev_ack`, once raised, stays high while `ev_req` is still high.
- R7: While `ev_req` is held high after `ev_ack` has risen, no new output request is raised and the count does not advance. The next event continues the sequence where it stopped.
- R8: A new output request is not raised while either output acknowledge is still high from the previous handshake.
- R9: The internal event count always lies in the range 0 to CYCLE_LEN-1.
- R10: A reset in the middle of a cycle makes the next event the first event of a fresh cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_req | input | 1 | Input channel request (one event per four-phase handshake) |
| ev_ack | output | 1 | Input channel acknowledge |
| step_req | output | 1 | Step channel request (events 1 to CYCLE_LEN-1) |
| step_ack | input | 1 | Step channel acknowledge |
| wrap_req | output | 1 | Wrap channel request (last event of a cycle) |
| wrap_ack | input | 1 | Wrap channel acknowledge |

## Verification
The counting function is run over several full cycles with randomized delays at every handshake phase. This shows that the choice of channel depends only on the event index, not on timing. One pattern holds the input request high long after its acknowledge. This separates a design that waits for return-to-zero from one that counts a held request again. Another pattern leaves the step acknowledge high while a new event arrives, which exposes an output request raised too early. A reset partway through a cycle tells apart a count that is truly cleared from one that only masks outputs.

// File: rtl/hs_mod_counter_pkg.sv
package hs_mod_counter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FIRE = 2'd1,
    ST_HOLD = 2'd2
  } seq_state_t;
endpackage

// File: rtl/hs_event_count.sv
module hs_event_count #(
  parameter int CYCLE_LEN = 6,
  localparam int CNT_W = (CYCLE_LEN > 1) ? $clog2(CYCLE_LEN) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic at_last
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (adv)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign at_last = (cnt_q == LAST);

  // R9: count stays inside 0..CYCLE_LEN-1
  p_cnt_range_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R2: the last count returns to zero after one advance
  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt_q == LAST) |=> cnt_q == '0);
endmodule

// File: rtl/hs_sequencer.sv
module hs_sequencer
  import hs_mod_counter_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ev_req,
  input  logic step_ack,
  input  logic wrap_ack,
  input  logic at_last,
  output logic ev_ack,
  output logic step_req,
  output logic wrap_req,
  output logic adv
);
  seq_state_t st_q, st_d;
  logic       sel_ack;

  assign sel_ack = at_last ? wrap_ack : step_ack;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (ev_req && !step_ack && !wrap_ack) st_d = ST_FIRE;
      ST_FIRE: if (sel_ack)                          st_d = ST_HOLD;
      ST_HOLD: if (!ev_req)                          st_d = ST_IDLE;
      default:                                       st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign adv      = (st_q == ST_FIRE) && sel_ack;
  assign step_req = (st_q == ST_FIRE) && !at_last;
  assign wrap_req = (st_q == ST_FIRE) && at_last;
  assign ev_ack   = (st_q == ST_HOLD);

  p_excl_req_r3: assert property (@(posedge clk) disable iff (rst)
    !(step_req && wrap_req));

  p_ack_after_out_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ev_ack) |-> $past(step_ack || wrap_ack));

  p_step_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (step_req && !step_ack) |=> step_req);

  p_wrap_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (wrap_req && !wrap_ack) |=> wrap_req);

  p_evack_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ev_ack && ev_req) |=> ev_ack);

  p_no_refire_r7: assert property (@(posedge clk) disable iff (rst)
    ev_ack |=> !(step_req || wrap_req));

  p_out_idle_first_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(step_req || wrap_req) |-> $past(!step_ack && !wrap_ack));
endmodule

// File: rtl/hs_mod_counter.sv
module hs_mod_counter #(
  parameter int CYCLE_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_req,
  output logic ev_ack,
  output logic step_req,
  input  logic step_ack,
  output logic wrap_req,
  input  logic wrap_ack
);
  logic adv;
  logic at_last;

  hs_event_count #(.CYCLE_LEN(CYCLE_LEN)) u_count (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .at_last (at_last)
  );

  hs_sequencer u_seq (
    .clk      (clk),
    .rst      (rst),
    .ev_req   (ev_req),
    .step_ack (step_ack),
    .wrap_ack (wrap_ack),
    .at_last  (at_last),
    .ev_ack   (ev_ack),
    .step_req (step_req),
    .wrap_req (wrap_req),
    .adv      (adv)
  );

  // R1: outputs quiet in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !(ev_ack || step_req || wrap_req));
endmodule

// File: tb/hs_mod_counter_tb.sv
module hs_mod_counter_tb;
  localparam int CYC = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_req = 1'b0;
  logic step_ack = 1'b0;
  logic wrap_ack = 1'b0;
  logic ev_ack, step_req, wrap_req;

  int checks = 0;
  int errors = 0;
  int pos = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hs_mod_counter #(.CYCLE_LEN(CYC)) u_dut (
    .clk(clk), .rst(rst), .ev_req(ev_req), .ev_ack(ev_ack),
    .step_req(step_req), .step_ack(step_ack),
    .wrap_req(wrap_req), .wrap_ack(wrap_ack)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_out(output bit seen);
    int n = 0;
    while (!step_req && !wrap_req && n < 40) begin @(negedge clk); n++; end
    seen = step_req || wrap_req;
  endtask

  task automatic wait_evack(input logic lvl);
    int n = 0;
    while (ev_ack !== lvl && n < 40) begin @(negedge clk); n++; end
    check(ev_ack === lvl, "R4/R6 ev_ack level reached", int'(ev_ack), int'(lvl));
  endtask

  // one event: request, answer, return to zero; checks channel choice
  task automatic do_event(input int hold_extra, input bit keep_ack);
    bit exp_w = (pos == CYC - 1);
    bit seen;
    @(negedge clk); ev_req = 1'b1;
    wait_out(seen);
    check(seen && step_req == !exp_w && wrap_req == exp_w,
          exp_w ? "R2 event 6 on wrap" : "R2 events 1-5 on step",
          {step_req, wrap_req}, exp_w ? 1 : 2);
    check(!(step_req && wrap_req), "R3 exclusive requests", {step_req, wrap_req}, 0);
    check(!ev_ack, "R4 no ev_ack before output ack", int'(ev_ack), 0);
    repeat ($urandom % 4) @(negedge clk);
    check(step_req || wrap_req, "R5 request held until ack", {step_req, wrap_req}, exp_w ? 1 : 2);
    if (exp_w) wrap_ack = 1'b1; else step_ack = 1'b1;
    wait_evack(1'b1);
    for (int i = 0; i < hold_extra; i++) begin
      @(negedge clk);
      check(ev_ack && !step_req && !wrap_req, "R6/R7 held request ignored",
            {ev_ack, step_req, wrap_req}, 4);
    end
    repeat ($urandom % 3) @(negedge clk);
    ev_req = 1'b0;
    wait_evack(1'b0);
    if (!keep_ack) begin
      repeat ($urandom % 3) @(negedge clk);
      step_ack = 1'b0; wrap_ack = 1'b0;
    end
    pos = (pos + 1) % CYC;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!ev_ack && !step_req && !wrap_req, "R1 outputs low in reset",
          {ev_ack, step_req, wrap_req}, 0);
    rst = 1'b0; pos = 0;
    do_event(0, 1'b0);  // R1: first event on step (checked inside)
  endtask

  task automatic t_cycles;
    // R2, R9: many full cycles, the count wraps back to event 1 each time
    for (int k = 0; k < 4 * CYC; k++) do_event(0, 1'b0);
  endtask

  task automatic t_held_req;
    // R7: request held high long after ack; sequence continues unchanged
    do_event(8, 1'b0);
    do_event(5, 1'b0);
    for (int k = 0; k < CYC; k++) do_event(0, 1'b0);
  endtask

  task automatic t_ack_linger;
    bit exp_w;
    bit seen;
    // R8: previous acknowledge left high blocks a new output request
    while (pos == CYC - 1) do_event(0, 1'b0);
    do_event(0, 1'b1);
    exp_w = (pos == CYC - 1);
    @(negedge clk); ev_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!step_req && !wrap_req, "R8 no request while ack still high",
            {step_req, wrap_req}, 0);
    end
    step_ack = 1'b0; wrap_ack = 1'b0;
    wait_out(seen);
    check(seen && step_req == !exp_w && wrap_req == exp_w, "R8 request after ack release",
          {step_req, wrap_req}, exp_w ? 1 : 2);
    if (exp_w) wrap_ack = 1'b1; else step_ack = 1'b1;
    wait_evack(1'b1);
    ev_req = 1'b0;
    wait_evack(1'b0);
    step_ack = 1'b0; wrap_ack = 1'b0;
    pos = (pos + 1) % CYC;
  endtask

  task automatic t_mid_reset;
    // R10: reset partway through a cycle restarts at event 1
    while (pos != 3) do_event(0, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(!ev_ack && !step_req && !wrap_req, "R10 outputs low after reset",
          {ev_ack, step_req, wrap_req}, 0);
    pos = 0;
    for (int k = 0; k < CYC + 1; k++) do_event(0, 1'b0);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd17));
    t_reset();
    t_cycles();
    t_held_req();
    t_ack_linger();
    t_mid_reset();
    repeat (4) @(negedge clk);
    summary();
  end
endmodule